// File: doc/BRIEF.md
# DDR Mode Register Command Unit

This block sits beside the command decoder of a DDR SDRAM device model and owns the base mode register. It samples the chip-select, row-strobe, column-strobe and write-enable pins on every rising clock edge. When all four are low, the cycle is a mode register set command. Bank-address bit 0 chooses between the base register and the extended register. A command is taken only when every bank reports idle, when the clock-enable pin was high on the previous edge and is high on the current edge, and when the unit is not inside the two-cycle write window of an earlier command.

An accepted base command decodes the row address into four settings: burst length, burst type, CAS latency and operating mode. CAS latency comes out as a count of half clock periods, so downstream logic handles whole numbers only. The settings stay as they are until another accepted command replaces them. A command with the DLL-reset operating mode also produces a single-cycle pulse. An accepted extended command produces only a single-cycle strobe.

Illegal commands set one sticky flag and reserved encodings set another. In both cases the stored settings stay unchanged. Both flags clear through a dedicated clear input.

Top module: `mrs_cmd_unit`

## Requirements
- R1: A mode register set command is an edge at which cs_n, ras_n, cas_n and we_n are all low. With bank_addr[0]=0 it targets the base settings. With bank_addr[0]=1 it is an extended command: if accepted, emrs_strobe is high for exactly the one cycle after the edge, and the base settings do not change.
- R2: A command is legal only when banks_idle is high, cke is high at the command edge, and cke was also high at the edge before it. An illegal command sets err_cmd and changes no setting.
- R3: busy is high for exactly the one cycle after an accepted command. If any command is presented at the edge that ends that cycle, it sets err_cmd and is not applied. Any command means cs_n low and not all of ras_n, cas_n and we_n high; a mode register set command counts.
- R4: Row address bits 2..0 select the burst length: 001 gives burst_len=2, 010 gives 4, and 011 gives 8.
- R5: Row address bit 3 selects the burst type: 0 gives burst_type=0 (sequential), and 1 gives burst_type=1 (interleaved).
- R6: Row address bits 6..4 select the CAS latency, reported in half clocks on cas_half: 101 gives 3 (1.5 clocks), 010 gives 4, 110 gives 5, and 011 gives 6.
- R7: Row address bits 12..7 select the operating mode. All zeros gives op_mode=0 (normal). Only bit 8 set gives op_mode=1 (normal with DLL reset), and dll_reset is then high for the one cycle after the edge. Only bit 7 set gives op_mode=2 (vendor test).
- R8: Some legal commands carry a reserved encoding: a burst-length code of 000 or 1xx, a CAS code of 000, 001, 100 or 111, any other operating-mode pattern, or a nonzero bank_addr bit above bit 0. Such a command sets err_enc, changes no setting, and raises neither busy nor any pulse.
- R9: err_cmd and err_enc stay high until err_clr is high at an edge. A new error at the same edge as err_clr leaves the flag set.
- R10: After reset the outputs are burst_len=2, burst_type=0, cas_half=4, op_mode=0, and busy, dll_reset, emrs_strobe, err_cmd and err_enc are all low.
- R11: The settings hold their values through cycles that carry no accepted base command, including deselected cycles (cs_n high) and NOP cycles, whatever the address pins carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_addr | input | BA_W | Bank address; bit 0 picks base or extended register |
| row_addr | input | ADDR_W | Row address carrying the mode fields |
| cke | input | 1 | Clock enable pin |
| banks_idle | input | 1 | High when all banks are precharged |
| err_clr | input | 1 | Clears both error flags |
| burst_len | output | 4 | Burst length in beats |
| burst_type | output | 1 | 0 sequential, 1 interleaved |
| cas_half | output | 3 | CAS latency in half clocks |
| op_mode | output | 2 | 0 normal, 1 DLL reset, 2 test |
| dll_reset | output | 1 | One-cycle pulse on an accepted DLL-reset command |
| emrs_strobe | output | 1 | One-cycle pulse on an accepted extended command |
| busy | output | 1 | Write window of an accepted command |
| err_cmd | output | 1 | Sticky illegal-command flag |
| err_enc | output | 1 | Sticky reserved-encoding flag |

## Verification
Every result of this block is due one clock after the edge that samples the command. The settings, busy, both pulses and both error flags are registered straight from that edge. The bench drives pins on the falling edge and reads results on the next falling edge, half a period after they change. A check on the busy window presents a second command on the edge right after acceptance. The expected error then shows at the falling edge after that second edge, and a further falling-edge check confirms that busy and the pulses have dropped again.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  typedef enum logic [1:0] {
    OPM_NORMAL  = 2'd0,
    OPM_DLL_RST = 2'd1,
    OPM_TEST    = 2'd2
  } opmode_e;

  typedef struct packed {
    logic [3:0] blen;
    logic       btype;
    logic [2:0] cas_half;
    opmode_e    mode;
  } mrs_cfg_t;

  // Field positions within the row address
  localparam int BL_LSB   = 0;
  localparam int BT_BIT   = 3;
  localparam int CL_LSB   = 4;
  localparam int MODE_LSB = 7;

  localparam mrs_cfg_t CFG_RESET = '{blen: 4'd2, btype: 1'b0,
                                     cas_half: 3'd4, mode: OPM_NORMAL};

endpackage

// File: rtl/mrs_field_dec.sv
module mrs_field_dec
  import mrs_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] row_addr,
  output mrs_cfg_t          dec_cfg,
  output logic              fields_ok
);

  localparam int MODE_W = ADDR_W - MODE_LSB;

  logic [2:0]        bl_code;
  logic [2:0]        cl_code;
  logic [MODE_W-1:0] mode_code;
  logic              bl_ok, cl_ok, mode_ok;

  assign bl_code   = row_addr[BL_LSB+2:BL_LSB];
  assign cl_code   = row_addr[CL_LSB+2:CL_LSB];
  assign mode_code = row_addr[ADDR_W-1:MODE_LSB];

  always_comb begin
    dec_cfg       = CFG_RESET;
    dec_cfg.btype = row_addr[BT_BIT];
    bl_ok         = 1'b1;
    cl_ok         = 1'b1;
    mode_ok       = 1'b1;

    unique case (bl_code)
      3'b001:  dec_cfg.blen = 4'd2;
      3'b010:  dec_cfg.blen = 4'd4;
      3'b011:  dec_cfg.blen = 4'd8;
      default: bl_ok = 1'b0;
    endcase

    unique case (cl_code)
      3'b101:  dec_cfg.cas_half = 3'd3;
      3'b010:  dec_cfg.cas_half = 3'd4;
      3'b110:  dec_cfg.cas_half = 3'd5;
      3'b011:  dec_cfg.cas_half = 3'd6;
      default: cl_ok = 1'b0;
    endcase

    if (mode_code == '0)
      dec_cfg.mode = OPM_NORMAL;
    else if (mode_code == MODE_W'(2))
      dec_cfg.mode = OPM_DLL_RST;
    else if (mode_code == MODE_W'(1))
      dec_cfg.mode = OPM_TEST;
    else
      mode_ok = 1'b0;
  end

  assign fields_ok = bl_ok & cl_ok & mode_ok;

endmodule

// File: rtl/mrs_cmd_guard.sv
module mrs_cmd_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic sel_ext,
  input  logic cke,
  input  logic banks_idle,
  input  logic base_ok,
  input  logic ext_ok,
  output logic accept_base,
  output logic accept_ext,
  output logic bad_cmd,
  output logic bad_enc,
  output logic busy
);

  logic cke_q, cke_d;
  logic busy_q, busy_d;
  logic mrs_hit, any_cmd, legal, enc_ok;

  // Next-state logic
  always_comb begin
    any_cmd     = !cs_n && !(ras_n && cas_n && we_n);
    mrs_hit     = !cs_n && !ras_n && !cas_n && !we_n;
    legal       = banks_idle && cke && cke_q && !busy_q;
    enc_ok      = sel_ext ? ext_ok : base_ok;
    accept_base = mrs_hit && legal && !sel_ext && enc_ok;
    accept_ext  = mrs_hit && legal &&  sel_ext && enc_ok;
    bad_cmd     = (mrs_hit && !legal) || (busy_q && any_cmd);
    bad_enc     = mrs_hit && legal && !enc_ok;
    busy_d      = accept_base || accept_ext;
    cke_d       = cke;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      cke_q  <= cke_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  assert_busy_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q);

  assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_base || accept_ext) |=> busy_q);

  assert_no_accept_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !(accept_base || accept_ext));

  assert_cke_history_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_base || accept_ext) |-> (cke_q && banks_idle));

endmodule

// File: rtl/mrs_cfg_store.sv
module mrs_cfg_store
  import mrs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     accept_base,
  input  logic     accept_ext,
  input  logic     bad_cmd,
  input  logic     bad_enc,
  input  logic     err_clr,
  input  mrs_cfg_t dec_cfg,
  output mrs_cfg_t cfg,
  output logic     dll_pulse,
  output logic     emrs_pulse,
  output logic     err_cmd,
  output logic     err_enc
);

  mrs_cfg_t cfg_q;
  logic     cfg_en;
  logic     dll_q, dll_d;
  logic     emrs_q, emrs_d;
  logic     ecmd_q, ecmd_d;
  logic     eenc_q, eenc_d;

  // Next-state logic
  always_comb begin
    cfg_en = accept_base;
    dll_d  = accept_base && (dec_cfg.mode == OPM_DLL_RST);
    emrs_d = accept_ext;
    ecmd_d = bad_cmd || (ecmd_q && !err_clr);
    eenc_d = bad_enc || (eenc_q && !err_clr);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RESET;
      dll_q  <= 1'b0;
      emrs_q <= 1'b0;
      ecmd_q <= 1'b0;
      eenc_q <= 1'b0;
    end else begin
      if (cfg_en) cfg_q <= dec_cfg;
      dll_q  <= dll_d;
      emrs_q <= emrs_d;
      ecmd_q <= ecmd_d;
      eenc_q <= eenc_d;
    end
  end

  assign cfg        = cfg_q;
  assign dll_pulse  = dll_q;
  assign emrs_pulse = emrs_q;
  assign err_cmd    = ecmd_q;
  assign err_enc    = eenc_q;

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_base |=> $stable(cfg_q));

  assert_dll_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dll_q |-> (cfg_q.mode == OPM_DLL_RST));

  assert_cas_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.cas_half >= 3'd3) && (cfg_q.cas_half <= 3'd6));

  assert_emrs_keeps_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ext |=> (emrs_q && $stable(cfg_q)));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ecmd_q && !err_clr) |=> ecmd_q);

  assert_reserved_no_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_enc |=> (!dll_q && !emrs_q && eenc_q));

endmodule

// File: rtl/mrs_cmd_unit.sv
module mrs_cmd_unit
  import mrs_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   bank_addr,
  input  logic [ADDR_W-1:0] row_addr,
  input  logic              cke,
  input  logic              banks_idle,
  input  logic              err_clr,
  output logic [3:0]        burst_len,
  output logic              burst_type,
  output logic [2:0]        cas_half,
  output logic [1:0]        op_mode,
  output logic              dll_reset,
  output logic              emrs_strobe,
  output logic              busy,
  output logic              err_cmd,
  output logic              err_enc
);

  logic     rst_s1, rst_s2;
  logic     ba_hi_ok, fields_ok;
  logic     accept_base, accept_ext, bad_cmd, bad_enc;
  mrs_cfg_t dec_cfg, cfg;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  generate
    if (BA_W > 1) begin : g_ba_hi
      assign ba_hi_ok = (bank_addr[BA_W-1:1] == '0);
    end else begin : g_ba_one
      assign ba_hi_ok = 1'b1;
    end
  endgenerate

  mrs_field_dec #(.ADDR_W(ADDR_W)) u_dec (
    .row_addr  (row_addr),
    .dec_cfg   (dec_cfg),
    .fields_ok (fields_ok)
  );

  mrs_cmd_guard u_guard (
    .clk         (clk),
    .rst_n       (rst_s2),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .sel_ext     (bank_addr[0]),
    .cke         (cke),
    .banks_idle  (banks_idle),
    .base_ok     (fields_ok && ba_hi_ok),
    .ext_ok      (ba_hi_ok),
    .accept_base (accept_base),
    .accept_ext  (accept_ext),
    .bad_cmd     (bad_cmd),
    .bad_enc     (bad_enc),
    .busy        (busy)
  );

  mrs_cfg_store u_store (
    .clk         (clk),
    .rst_n       (rst_s2),
    .accept_base (accept_base),
    .accept_ext  (accept_ext),
    .bad_cmd     (bad_cmd),
    .bad_enc     (bad_enc),
    .err_clr     (err_clr),
    .dec_cfg     (dec_cfg),
    .cfg         (cfg),
    .dll_pulse   (dll_reset),
    .emrs_pulse  (emrs_strobe),
    .err_cmd     (err_cmd),
    .err_enc     (err_enc)
  );

  assign burst_len  = cfg.blen;
  assign burst_type = cfg.btype;
  assign cas_half   = cfg.cas_half;
  assign op_mode    = cfg.mode;

endmodule

// File: tb/mrs_cmd_unit_tb.sv
`timescale 1ns/1ps
module mrs_cmd_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, ras_n, cas_n, we_n, cke, banks_idle, err_clr;
  logic [1:0]  bank_addr;
  logic [12:0] row_addr;
  logic [3:0]  burst_len;
  logic        burst_type;
  logic [2:0]  cas_half;
  logic [1:0]  op_mode;
  logic        dll_reset, emrs_strobe, busy, err_cmd, err_enc;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  mrs_cmd_unit u_dut (
    .clk, .rst_n, .cs_n, .ras_n, .cas_n, .we_n, .bank_addr, .row_addr,
    .cke, .banks_idle, .err_clr, .burst_len, .burst_type, .cas_half,
    .op_mode, .dll_reset, .emrs_strobe, .busy, .err_cmd, .err_enc
  );

  // {bank, addr, blen, btype, cas_half, mode, err_enc, dll, emrs}
  localparam int NV = 11;
  localparam logic [27:0] VECS [NV] = '{
    {2'd0, 13'h021, 4'd2, 1'b0, 3'd4, 2'd0, 1'b0, 1'b0, 1'b0},
    {2'd0, 13'h03A, 4'd4, 1'b1, 3'd6, 2'd0, 1'b0, 1'b0, 1'b0},
    {2'd0, 13'h153, 4'd8, 1'b0, 3'd3, 2'd1, 1'b0, 1'b1, 1'b0},
    {2'd0, 13'h0E9, 4'd2, 1'b1, 3'd5, 2'd2, 1'b0, 1'b0, 1'b0},
    {2'd0, 13'h020, 4'd2, 1'b1, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0},
    {2'd0, 13'h072, 4'd2, 1'b1, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0},
    {2'd0, 13'h221, 4'd2, 1'b1, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0},
    {2'd0, 13'h024, 4'd2, 1'b1, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0},
    {2'd0, 13'h1A1, 4'd2, 1'b1, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0},
    {2'd1, 13'h000, 4'd2, 1'b1, 3'd5, 2'd2, 1'b0, 1'b0, 1'b1},
    {2'd2, 13'h03A, 4'd2, 1'b1, 3'd5, 2'd2, 1'b1, 1'b0, 1'b0}
  };

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_cfg(input string tag, input int bl, input int bt,
                         input int cl, input int om);
    chk({tag, " burst_len (R4)"}, int'(burst_len), bl);
    chk({tag, " burst_type (R5)"}, int'(burst_type), bt);
    chk({tag, " cas_half (R6)"}, int'(cas_half), cl);
    chk({tag, " op_mode (R7)"}, int'(op_mode), om);
  endtask

  task automatic pins_nop();
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic pins_mrs(input logic [1:0] ba, input logic [12:0] a);
    cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0;
    bank_addr = ba; row_addr = a;
  endtask

  // Drive command for one edge, return at the falling edge after it
  task automatic issue(input logic [1:0] ba, input logic [12:0] a);
    @(negedge clk); pins_mrs(ba, a);
    @(negedge clk); pins_nop();
  endtask

  task automatic clear_errs();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
        finish_run();
      end
    end
  end

  initial begin
    rst_n = 1'b0; pins_nop(); bank_addr = '0; row_addr = '0;
    cke = 1'b0; banks_idle = 1'b1; err_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset values
    chk_cfg("R10 reset", 2, 0, 4, 0);
    chk("R10 busy", int'(busy), 0);
    chk("R10 dll_reset", int'(dll_reset), 0);
    chk("R10 emrs_strobe", int'(emrs_strobe), 0);
    chk("R10 err_cmd", int'(err_cmd), 0);
    chk("R10 err_enc", int'(err_enc), 0);

    cke = 1'b1;
    @(negedge clk);

    // Vector table: R1 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VECS[i];
      issue(v[27:26], v[25:13]);
      chk_cfg($sformatf("vec%0d", i), int'(v[12:9]), int'(v[8]),
              int'(v[7:5]), int'(v[4:3]));
      chk($sformatf("vec%0d err_enc R8", i), int'(err_enc), int'(v[2]));
      chk($sformatf("vec%0d dll_reset R7", i), int'(dll_reset), int'(v[1]));
      chk($sformatf("vec%0d emrs_strobe R1", i), int'(emrs_strobe), int'(v[0]));
      chk($sformatf("vec%0d busy R3", i), int'(busy), int'(!v[2]));
      @(negedge clk);
      chk($sformatf("vec%0d busy drop R3", i), int'(busy), 0);
      chk($sformatf("vec%0d pulses drop R7", i), int'(dll_reset | emrs_strobe), 0);
      if (v[2]) begin
        chk($sformatf("vec%0d err_enc sticky R9", i), int'(err_enc), 1);
        clear_errs();
        chk($sformatf("vec%0d err_enc cleared R9", i), int'(err_enc), 0);
      end
    end

    // R2 banks not idle
    banks_idle = 1'b0;
    issue(2'd0, 13'h03A);
    chk("R2 banks busy err_cmd", int'(err_cmd), 1);
    chk_cfg("R2 banks busy", 2, 1, 5, 2);
    chk("R2 banks busy no busy", int'(busy), 0);
    banks_idle = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 err_cmd sticky", int'(err_cmd), 1);

    // R9 set wins over clear at same edge
    @(negedge clk); banks_idle = 1'b0; err_clr = 1'b1; pins_mrs(2'd0, 13'h021);
    @(negedge clk); pins_nop(); err_clr = 1'b0; banks_idle = 1'b1;
    chk("R9 set beats clear", int'(err_cmd), 1);
    clear_errs();
    chk("R9 err_cmd cleared", int'(err_cmd), 0);

    // R2 cke low on previous edge
    @(negedge clk); cke = 1'b0;
    @(negedge clk); cke = 1'b1; pins_mrs(2'd0, 13'h021);
    @(negedge clk); pins_nop();
    chk("R2 cke history err_cmd", int'(err_cmd), 1);
    chk_cfg("R2 cke history", 2, 1, 5, 2);
    clear_errs();
    issue(2'd0, 13'h021);
    chk("R2 legal accepted err_cmd", int'(err_cmd), 0);
    chk_cfg("R2 legal accepted", 2, 0, 4, 0);
    @(negedge clk);

    // R3 second MRS inside the write window
    issue(2'd0, 13'h03A);
    chk("R3 busy high", int'(busy), 1);
    pins_mrs(2'd0, 13'h153);
    @(negedge clk); pins_nop();
    chk("R3 mrs in window err_cmd", int'(err_cmd), 1);
    chk_cfg("R3 mrs in window", 4, 1, 6, 0);
    chk("R3 mrs in window no dll", int'(dll_reset), 0);
    clear_errs();

    // R3 other command inside the window
    issue(2'd0, 13'h021);
    cs_n = 1'b0; ras_n = 1'b0;
    @(negedge clk); pins_nop();
    chk("R3 activate in window err_cmd", int'(err_cmd), 1);
    chk_cfg("R3 activate in window", 2, 0, 4, 0);
    clear_errs();

    // R11 hold through deselect and NOP cycles
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cs_n = (k % 2 == 0); ras_n = (k % 2 != 0); cas_n = (k % 2 != 0);
      we_n = (k % 2 != 0);
      row_addr = 13'(16'h1357 * (k + 1)); bank_addr = 2'(k);
    end
    @(negedge clk); pins_nop();
    @(negedge clk);
    chk_cfg("R11 hold", 2, 0, 4, 0);
    chk("R11 no error", int'(err_cmd | err_enc), 0);
    chk("R1 no strobe on deselect", int'(emrs_strobe), 0);

    finish_run();
  end

endmodule